// File: doc/BRIEF.md
# Erasable Programmable Byte Memory Model

This block is a synthesizable, clock-based model of a 2048 x 8 ultraviolet-erasable programmable memory. It is meant to stand in for the device as a device under test or inside an emulation platform. Three control inputs select the operating mode: an active-low chip select that doubles as the programming strobe, an active-low output enable, and a flag that says the programming supply is raised. The data pins appear as three signals: an input byte, an output byte and an output-drive enable.

Programming works only by clearing bits. A strobe that rises while the programming supply is raised and the output enable is high captures the address and input byte. When the strobe falls, and only if its width lies inside the legal window, the captured byte is ANDed into the stored byte. A strobe that is too short or too long sets an error flag and writes nothing. The width window comes from a clock-frequency parameter. A bulk-erase request sweeps every location back to 0xFF, one location per cycle, and reset starts the same sweep so that the array always begins in a known state.

Top module: `eprom_model`

## Requirements
- R1: With chip select low, output enable low and the programming supply not raised (read), `dout_en` is 1 one clock after the inputs are sampled, and `dout` holds the byte stored at `addr`.
- R2: With output enable high and the programming supply not raised, `dout_en` is 0 one clock later, whatever level chip select has.
- R3: With chip select high and the programming supply not raised, `dout_en` is 0 one clock later, whatever level output enable has.
- R4: With the programming supply raised, chip select low and output enable low (verify), the stored byte at `addr` is driven as in R1.
- R5: A strobe is legal when chip select is sampled high on W consecutive clock edges, with `vpp_hi`=1 and `oe_n`=1 at every one of those edges and at the edge where it is first sampled low again, and MIN_CYC <= W <= MAX_CYC. A legal strobe replaces the stored byte at the address captured on the rising edge with (old AND din), where din is also captured on the rising edge. `dout_en` stays 0 throughout.
- R6: With the programming supply raised, output enable high and chip select held low (inhibit), `dout_en` stays 0 and no stored byte changes.
- R7: A strobe with W < MIN_CYC, or one still high on its (MAX_CYC+1)-th edge, sets `pulse_err` to 1 and writes nothing. `pulse_err` holds until the rising edge of the next strobe that is accepted for tracking.
- R8: A chip-select high pulse with `vpp_hi`=0 has no effect on the stored contents or on `pulse_err`.
- R9: After reset, and after `bulk_erase` is sampled 1 while idle, `busy` is 1 for DEPTH clocks. During that time `dout_en` is 0, and afterwards every location reads 0xFF.
- R10: Programming never sets a bit: a second legal strobe with din = 0xFF leaves a byte unchanged, and one with another byte yields the AND of both.
- R11: MIN_CYC = (CLK_HZ/1000)*PULSE_MIN_MS and MAX_CYC = (CLK_HZ/1000)*PULSE_MAX_MS. Widths of exactly MIN_CYC and MAX_CYC are legal; MIN_CYC-1 and MAX_CYC+1 are not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the time base for strobe widths |
| rst | input | 1 | Synchronous active-high reset; starts an erase sweep |
| addr | input | 11 | Byte address |
| ce_n | input | 1 | Active-low chip select; its high pulse is the programming strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | 1 when the programming supply is raised |
| din | input | 8 | Byte presented on the data pins while programming |
| dout | output | 8 | Byte read from the array |
| dout_en | output | 1 | 1 when the data pins are driven |
| bulk_erase | input | 1 | Request to set every byte to 0xFF |
| busy | output | 1 | Erase sweep in progress |
| pulse_err | output | 1 | Last strobe had an illegal width |

## Verification
The properties assume that the control inputs change once per clock and are sampled cleanly at the rising edge. They also assume that address and input byte stay stable for the whole strobe, because the model captures them only at its start. The stimulus changes inputs only on falling clock edges and holds address and data from several cycles before each strobe until after it. It never starts an erase while a strobe is open, and it never drops the programming supply and chip select in the same cycle. A behavioural reference, built from width counts and a plain byte array, is compared with the outputs on every clock.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    MODE_READ,
    MODE_DESEL,
    MODE_STBY,
    MODE_PROG,
    MODE_VERIFY,
    MODE_INHIBIT
  } eprom_mode_t;

  // Six-way decode of the three control inputs.
  function automatic eprom_mode_t decode_mode(input logic ce_n, input logic oe_n,
                                              input logic vpp_hi);
    eprom_mode_t m;
    if (vpp_hi) begin
      if (!ce_n && !oe_n)     m = MODE_VERIFY;
      else if (ce_n && oe_n)  m = MODE_PROG;
      else if (oe_n)          m = MODE_INHIBIT;
      else                    m = MODE_STBY;
    end else begin
      if (ce_n)               m = MODE_STBY;
      else if (oe_n)          m = MODE_DESEL;
      else                    m = MODE_READ;
    end
    return m;
  endfunction

endpackage

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // One write port and one registered read port: simple dual-port RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eprom_erase_seq.sv
module eprom_erase_seq #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] waddr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b1;
      waddr <= '0;
    end else if (busy) begin
      if (waddr == LAST) busy <= 1'b0;
      waddr <= waddr + 1'b1;
    end else if (start) begin
      busy  <= 1'b1;
      waddr <= '0;
    end
  end
endmodule

// File: rtl/eprom_pulse_chk.sv
module eprom_pulse_chk #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int MIN_CYC = 4500,
  parameter int MAX_CYC = 5500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              active,
  output logic              commit,
  output logic [ADDR_W-1:0] pa,
  output logic [DATA_W-1:0] pd,
  output logic              pulse_err
);
  localparam int CNT_W = $clog2(MAX_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] LO = CNT_W'(MIN_CYC);
  localparam logic [CNT_W-1:0] HI = CNT_W'(MAX_CYC);

  logic             ce_q;
  logic             bad;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise = ce_n && !ce_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q      <= 1'b1;
      active    <= 1'b0;
      commit    <= 1'b0;
      bad       <= 1'b0;
      cnt       <= '0;
      pa        <= '0;
      pd        <= '0;
      pulse_err <= 1'b0;
    end else begin
      ce_q   <= ce_n;
      commit <= 1'b0;
      if (abort) begin
        active <= 1'b0;
      end else if (!active) begin
        if (rise && vpp_hi && oe_n) begin
          active    <= 1'b1;
          cnt       <= CNT_W'(1);
          pa        <= addr;
          pd        <= din;
          bad       <= 1'b0;
          pulse_err <= 1'b0;
        end
      end else if (!vpp_hi || !oe_n) begin
        active <= 1'b0;                 // supply or enable left the program mode
      end else if (ce_n) begin
        if (cnt >= HI) begin
          bad       <= 1'b1;            // too long: flag without waiting for the end
          pulse_err <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        active <= 1'b0;
        if (!bad && cnt >= LO) commit    <= 1'b1;
        else                   pulse_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eprom_model.sv
module eprom_model #(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int CLK_HZ       = 50_000_000,
  parameter int PULSE_MIN_MS = 45,
  parameter int PULSE_MAX_MS = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic              bulk_erase,
  output logic              busy,
  output logic              pulse_err
);
  import eprom_pkg::*;

  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int MIN_CYC    = CYC_PER_MS * PULSE_MIN_MS;
  localparam int MAX_CYC    = CYC_PER_MS * PULSE_MAX_MS;

  eprom_mode_t       mode;
  logic              drive;
  logic              p_active, p_commit;
  logic [ADDR_W-1:0] p_addr, e_addr, rd_addr, wr_addr;
  logic [DATA_W-1:0] p_data, rdata, wr_data;
  logic              wr_en;

  assign mode  = decode_mode(ce_n, oe_n, vpp_hi);
  assign drive = (mode == MODE_READ) || (mode == MODE_VERIFY);

  eprom_erase_seq #(.ADDR_W(ADDR_W)) u_erase (
    .clk   (clk),
    .rst   (rst),
    .start (bulk_erase),
    .busy  (busy),
    .waddr (e_addr)
  );

  eprom_pulse_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MIN_CYC(MIN_CYC),
    .MAX_CYC(MAX_CYC)
  ) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .abort    (busy | bulk_erase),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .vpp_hi   (vpp_hi),
    .addr     (addr),
    .din      (din),
    .active   (p_active),
    .commit   (p_commit),
    .pa       (p_addr),
    .pd       (p_data),
    .pulse_err(pulse_err)
  );

  // While a strobe is open the read port follows the captured address, so the
  // old byte is in rdata when the commit cycle needs it.
  assign rd_addr = p_active ? p_addr : addr;
  assign wr_en   = busy | p_commit;
  assign wr_addr = busy ? e_addr : p_addr;
  assign wr_data = busy ? {DATA_W{1'b1}} : (rdata & p_data);

  eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(rd_addr),
    .rdata(rdata)
  );

  assign dout = rdata;

  always_ff @(posedge clk) begin
    if (rst) dout_en <= 1'b0;
    else     dout_en <= drive && !busy;
  end
endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic oe_n,
  input logic vpp_hi,
  input logic dout_en,
  input logic busy,
  input logic pulse_err
);
  // R1 / R4: both drive modes turn the pins on one clock later when idle
  assert_drive_on_R1: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && !busy) |=> dout_en);

  assert_deselect_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    (oe_n && !vpp_hi) |=> !dout_en);

  assert_standby_hiz_R3: assert property (@(posedge clk) disable iff (rst)
    (ce_n && !vpp_hi) |=> !dout_en);

  // R5 / R6: program and inhibit never drive the pins
  assert_program_hiz_R5: assert property (@(posedge clk) disable iff (rst)
    (vpp_hi && oe_n) |=> !dout_en);

  assert_erase_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> !dout_en);

  assert_err_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_err) |-> ($past(vpp_hi) && $past(oe_n)));

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_err) |-> ($past(ce_n) && $past(vpp_hi) && $past(oe_n)));
endmodule

bind eprom_model eprom_model_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .vpp_hi   (vpp_hi),
  .dout_en  (dout_en),
  .busy     (busy),
  .pulse_err(pulse_err)
);

// File: tb/eprom_model_test.sv
module eprom_model_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int CLK_HZ     = 100_000;
  localparam int MIN_W      = (CLK_HZ / 1000) * 45;
  localparam int MAX_W      = (CLK_HZ / 1000) * 55;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] addr = '0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        vpp_hi = 1'b0;
  logic [7:0]  din = '0;
  logic        bulk_erase = 1'b0;
  logic [7:0]  dout;
  logic        dout_en, busy, pulse_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_model #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .din(din), .dout(dout), .dout_en(dout_en),
    .bulk_erase(bulk_erase), .busy(busy), .pulse_err(pulse_err)
  );

  // ---------------- behavioural reference ----------------
  int    mem_ref [DEPTH];
  int    r_busy = 1, r_ecnt = 0, r_en = 0, r_dout = 0, r_err = 0;
  int    r_act = 0, r_w = 0, r_pa = 0, r_pd = 0, r_pend = 0, prev_ce = 1;
  int    busy_old, rd_a;
  string r_tag = "R9";

  always @(posedge clk) begin
    if (rst) begin
      r_busy = 1; r_ecnt = 0; r_en = 0; r_err = 0; r_act = 0;
      r_pend = 0; prev_ce = 1; r_tag = "R9";
    end else begin
      busy_old = r_busy;
      rd_a     = r_act ? r_pa : int'(addr);
      r_en     = (!busy_old && !ce_n && !oe_n) ? 1 : 0;
      r_dout   = mem_ref[rd_a];
      if (busy_old)              r_tag = "R9";
      else if (r_en && vpp_hi)   r_tag = "R4";
      else if (r_en)             r_tag = "R1";
      else if (vpp_hi)           r_tag = "R6";
      else if (ce_n)             r_tag = "R3";
      else                       r_tag = "R2";
      if (r_pend) begin
        mem_ref[r_pa] = mem_ref[r_pa] & r_pd;
        r_pend = 0;
      end
      if (busy_old || bulk_erase) r_act = 0;
      else if (!r_act) begin
        if (ce_n && !prev_ce && vpp_hi && oe_n) begin
          r_act = 1; r_w = 1; r_pa = int'(addr); r_pd = int'(din); r_err = 0;
        end
      end else if (!vpp_hi || !oe_n) r_act = 0;
      else if (ce_n) begin
        r_w++;
        if (r_w > MAX_W) r_err = 1;
      end else begin
        r_act = 0;
        if (r_w >= MIN_W && r_w <= MAX_W) r_pend = 1;
        else r_err = 1;
      end
      if (busy_old) begin
        mem_ref[r_ecnt] = 'hFF;
        if (r_ecnt == DEPTH - 1) r_busy = 0;
        r_ecnt = (r_ecnt + 1) % DEPTH;
      end else if (bulk_erase) begin
        r_busy = 1; r_ecnt = 0;
      end
      prev_ce = ce_n ? 1 : 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({r_tag, " dout_en"}, 32'(dout_en), 32'(r_en));
      check("R9 busy", 32'(busy), 32'(r_busy));
      check("R7 pulse_err", 32'(pulse_err), 32'(r_err));
      if (r_en != 0) check({r_tag, " dout"}, 32'(dout), 32'(r_dout));
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_byte(input string tag, input int a, input bit vpp, input int exp);
    addr = 11'(a); vpp_hi = vpp; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check({tag, " drive"}, 32'(dout_en), 32'd1);
    check({tag, " byte"}, 32'(dout), 32'(exp));
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe(input int a, input int d, input int width, input bit vpp);
    vpp_hi = vpp; oe_n = 1'b1; ce_n = 1'b0; addr = 11'(a); din = 8'(d);
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    repeat (width) begin
      @(negedge clk);
      if (vpp) check("R5 no drive in strobe", 32'(dout_en), 32'd0);
    end
    ce_n = 1'b0;
    repeat (4) @(negedge clk);
    vpp_hi = 1'b0; ce_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset dout_en", 32'(dout_en), 32'd0);
    check("R9 reset busy", 32'(busy), 32'd1);
    rst = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);

    read_byte("R9 erased low", 0, 1'b0, 'hFF);
    read_byte("R9 erased top", DEPTH - 1, 1'b0, 'hFF);

    strobe(5, 'hA5, 5000, 1'b1);
    check("R5 err after good strobe", 32'(pulse_err), 32'd0);
    read_byte("R4 verify", 5, 1'b1, 'hA5);
    read_byte("R1 read", 5, 1'b0, 'hA5);

    strobe(5, 'h0F, 5000, 1'b1);
    read_byte("R10 and", 5, 1'b0, 'h05);
    strobe(5, 'hFF, 5000, 1'b1);
    read_byte("R10 ff keeps", 5, 1'b0, 'h05);

    strobe(6, 'h00, MIN_W - 1, 1'b1);
    check("R11 short err", 32'(pulse_err), 32'd1);
    read_byte("R7 short no write", 6, 1'b0, 'hFF);
    strobe(7, 'h3C, MIN_W, 1'b1);
    check("R11 min clears err", 32'(pulse_err), 32'd0);
    read_byte("R11 min written", 7, 1'b0, 'h3C);
    strobe(8, 'hC3, MAX_W, 1'b1);
    check("R11 max ok", 32'(pulse_err), 32'd0);
    read_byte("R11 max written", 8, 1'b0, 'hC3);
    strobe(9, 'h00, MAX_W + 1, 1'b1);
    check("R11 long err", 32'(pulse_err), 32'd1);
    read_byte("R7 long no write", 9, 1'b0, 'hFF);

    strobe(10, 'h00, 5000, 1'b0);
    check("R8 err untouched", 32'(pulse_err), 32'd1);
    read_byte("R8 no write", 10, 1'b0, 'hFF);

    // inhibit: supply raised, strobe held low
    vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b0; addr = 11'd7; din = 8'h00;
    repeat (20) @(negedge clk);
    check("R6 inhibit hiz", 32'(dout_en), 32'd0);
    idle(2);
    read_byte("R6 unchanged", 7, 1'b0, 'h3C);

    // deselect and standby in both levels of the other pin
    ce_n = 1'b0; oe_n = 1'b1; addr = 11'd7; @(negedge clk);
    check("R2 deselect", 32'(dout_en), 32'd0);
    ce_n = 1'b1; oe_n = 1'b1; @(negedge clk);
    check("R2 deselect ce high", 32'(dout_en), 32'd0);
    ce_n = 1'b1; oe_n = 1'b0; @(negedge clk);
    check("R3 standby", 32'(dout_en), 32'd0);
    idle(2);

    bulk_erase = 1'b1; @(negedge clk); bulk_erase = 1'b0;
    check("R9 erase busy", 32'(busy), 32'd1);
    ce_n = 1'b0; oe_n = 1'b0; addr = 11'd5;
    repeat (10) @(negedge clk);
    check("R9 quiet while busy", 32'(dout_en), 32'd0);
    idle(1);
    while (busy) @(negedge clk);
    @(negedge clk);
    read_byte("R9 erased 5", 5, 1'b0, 'hFF);
    read_byte("R9 erased 7", 7, 1'b0, 'hFF);
    read_byte("R9 erased 8", 8, 1'b0, 'hFF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog got hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule